// File: doc/BRIEF.md
# Quadrature NCO with Phase Offset

This block is a numerically controlled oscillator with two outputs, cosine and sine. Each clock cycle a 32-bit phase accumulator adds a programmable frequency word. A 16-bit phase offset is then added to the upper half of the accumulated phase. The top bits of the result drive a quarter-wave lookup, which produces signed cosine and sine samples of the same angle. If the frequency word stays fixed and the offset is zero, the output is a vector that rotates at constant speed, which suits tuning and down-conversion. Changing the offset gives phase modulation, and changing the frequency word gives frequency modulation.

Software writes the frequency word and the offset word into holding registers through a small write port. A separate load strobe copies both holding registers into the active registers on the same edge, so the accumulator never works with a half-updated pair. Three discrete inputs control the accumulator: enable lets it advance, clear forces it to zero, and load commits the staged words.

Top module: `nco_quad`

## Requirements
- R1: While reset is asserted, `cos_o` and `sin_o` read 0, and the accumulator, the holding registers and the active registers are all zero.
- R2: A write with `wr_sel_i`=0 stores `wr_data_i` as the staged frequency word. A write with `wr_sel_i`=1 stores `wr_data_i[15:0]` as the staged offset. A write alone has no effect on the outputs.
- R3: On an edge with `load_i` high, both staged words become active together. If a write happens on that same edge, the load takes the staged value from before that write.
- R4: On each edge with `enable_i` high and `clear_i` low, the accumulator adds the active frequency word, modulo 2^32.
- R5: On an edge with `enable_i` low and `clear_i` low, the accumulator holds its value, so the outputs settle at a fixed value.
- R6: On an edge with `clear_i` high, the accumulator becomes zero, whatever `enable_i` is.
- R7: The phase equals the accumulator plus the active offset shifted left by 16, modulo 2^32.
- R8: With k equal to phase bits [31:22] and angle a = 2*pi*(k+0.5)/1024, `sin_o` = round(32767*sin a) and `cos_o` = round(32767*cos a). Both are two's-complement values, and the two MSBs of the phase select the quadrant.
- R9: A change made to the accumulator or to the active offset on edge e appears on the outputs on edge e+3.
- R10: Neither output ever takes the value -32768, so the outputs are symmetric about zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the holding registers |
| wr_sel_i | input | 1 | Target: 0 = frequency word, 1 = phase offset |
| wr_data_i | input | 32 | Write data; the offset takes bits [15:0] |
| load_i | input | 1 | Copies both staged words into the active registers |
| enable_i | input | 1 | Lets the accumulator advance |
| clear_i | input | 1 | Forces the accumulator to zero |
| cos_o | output | 16 | Signed cosine sample |
| sin_o | output | 16 | Signed sine sample |

## Verification
The hardest case to reach is a sweep through all 1024 table points in all four quadrants. The bench gets there by loading a frequency word that moves the index by one step per cycle and running a full turn. It also loads offsets near the end of the range, so the phase sum wraps past 2^32. The same-edge write and load is driven on purpose, so the bench can show that the stale staged word was the one committed. A per-cycle reference model, built on real-valued sine and cosine, checks the three-edge latency after every clear, freeze and load.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic {
    SEL_FREQ = 1'b0,
    SEL_POFF = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl #(
  parameter int FREQ_W = 32,
  parameter int POFF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [FREQ_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [FREQ_W-1:0] freq_hold_o,
  output logic [POFF_W-1:0] poff_hold_o,
  output logic [FREQ_W-1:0] freq_act_o,
  output logic [POFF_W-1:0] poff_act_o
);
  import nco_pkg::*;

  wr_sel_e sel;
  assign sel = wr_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_hold_o <= '0;
      poff_hold_o <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_FREQ) freq_hold_o <= wr_data_i;
      else                 poff_hold_o <= wr_data_i[POFF_W-1:0];
    end
  end

  // commit both words on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_act_o <= '0;
      poff_act_o <= '0;
    end else if (load_i) begin
      freq_act_o <= freq_hold_o;
      poff_act_o <= poff_hold_o;
    end
  end
endmodule

// File: rtl/nco_phase.sv
module nco_phase #(
  parameter int PHASE_W = 32,
  parameter int POFF_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               clear_i,
  input  logic [PHASE_W-1:0] freq_i,
  input  logic [POFF_W-1:0]  poff_i,
  output logic [PHASE_W-1:0] acc_o,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int PAD_W = PHASE_W - POFF_W;

  logic [PHASE_W-1:0] poff_al;
  assign poff_al = {poff_i, {PAD_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_o <= '0;
    else if (clear_i)  acc_o <= '0;
    else if (enable_i) acc_o <= acc_o + freq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= '0;
    else         phase_o <= acc_o + poff_al;
  end
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 8,
  parameter int AMP_W   = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PHASE_W-1:0]      phase_i,
  output logic signed [AMP_W-1:0] cos_o,
  output logic signed [AMP_W-1:0] sin_o
);
  localparam int  LUT_N   = 1 << LUT_AW;
  localparam int  IDX_LO  = PHASE_W - 2 - LUT_AW;
  localparam real AMP_MAX = real'((1 << (AMP_W - 1)) - 1);
  localparam real PI      = 3.14159265358979323846;

  logic [AMP_W-1:0] rom [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_rom
    localparam real ANG = PI * (real'(g) + 0.5) / (2.0 * real'(LUT_N));
    localparam int  VAL = $rtoi(AMP_MAX * $sin(ANG) + 0.5);
    assign rom[g] = AMP_W'(VAL);
  end

  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx, idx_s, idx_c;
  logic              unused_lsb;

  assign quad       = phase_i[PHASE_W-1 -: 2];
  assign idx        = phase_i[PHASE_W-3 -: LUT_AW];
  assign unused_lsb = ^phase_i[IDX_LO-1:0];
  // odd quadrants read the table mirrored
  assign idx_s = quad[0] ? ~idx : idx;
  assign idx_c = quad[0] ? idx : ~idx;

  logic [AMP_W-1:0] mag_s, mag_c;
  logic             neg_s, neg_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_s <= '0;
      mag_c <= '0;
      neg_s <= 1'b0;
      neg_c <= 1'b0;
    end else begin
      mag_s <= rom[idx_s];
      mag_c <= rom[idx_c];
      neg_s <= quad[1];
      neg_c <= quad[1] ^ quad[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= neg_s ? -mag_s : mag_s;
      cos_o <= neg_c ? -mag_c : mag_c;
    end
  end
endmodule

// File: rtl/nco_quad.sv
module nco_quad #(
  parameter int PHASE_W = 32,
  parameter int POFF_W  = 16,
  parameter int LUT_AW  = 8,
  parameter int AMP_W   = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    wr_sel_i,
  input  logic [PHASE_W-1:0]      wr_data_i,
  input  logic                    load_i,
  input  logic                    enable_i,
  input  logic                    clear_i,
  output logic signed [AMP_W-1:0] cos_o,
  output logic signed [AMP_W-1:0] sin_o
);
  logic [PHASE_W-1:0] freq_hold, freq_act, acc_q, phase_q;
  logic [POFF_W-1:0]  poff_hold, poff_act;

  nco_ctrl #(.FREQ_W(PHASE_W), .POFF_W(POFF_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .load_i     (load_i),
    .freq_hold_o(freq_hold),
    .poff_hold_o(poff_hold),
    .freq_act_o (freq_act),
    .poff_act_o (poff_act)
  );

  nco_phase #(.PHASE_W(PHASE_W), .POFF_W(POFF_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .clear_i (clear_i),
    .freq_i  (freq_act),
    .poff_i  (poff_act),
    .acc_o   (acc_q),
    .phase_o (phase_q)
  );

  nco_sincos #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_sincos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase_q),
    .cos_o  (cos_o),
    .sin_o  (sin_o)
  );
endmodule

// File: rtl/nco_quad_chk.sv
module nco_quad_chk #(
  parameter int PHASE_W = 32,
  parameter int POFF_W  = 16,
  parameter int AMP_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               enable_i,
  input logic               clear_i,
  input logic [PHASE_W-1:0] acc_q,
  input logic [PHASE_W-1:0] freq_act,
  input logic [PHASE_W-1:0] freq_hold,
  input logic [POFF_W-1:0]  poff_act,
  input logic [POFF_W-1:0]  poff_hold,
  input logic [AMP_W-1:0]   cos_o,
  input logic [AMP_W-1:0]   sin_o
);
  localparam logic [AMP_W-1:0] AMP_MIN = {1'b1, {(AMP_W-1){1'b0}}};

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_q == '0); // R6
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !enable_i) |=> $stable(acc_q)); // R5
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && enable_i) |=> acc_q == $past(acc_q) + $past(freq_act)); // R4
  AST_LOAD_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (freq_act == $past(freq_hold)) && (poff_act == $past(poff_hold))); // R3
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(freq_act) && $stable(poff_act)); // R2
  AST_NO_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_o != AMP_MIN) && (cos_o != AMP_MIN)); // R10
endmodule

bind nco_quad nco_quad_chk #(.PHASE_W(PHASE_W), .POFF_W(POFF_W), .AMP_W(AMP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .enable_i (enable_i),
  .clear_i  (clear_i),
  .acc_q    (acc_q),
  .freq_act (freq_act),
  .freq_hold(freq_hold),
  .poff_act (poff_act),
  .poff_hold(poff_hold),
  .cos_o    (cos_o),
  .sin_o    (sin_o)
);

// File: tb/tb_nco_quad.sv
module tb_nco_quad;
  localparam int  CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979323846;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0, load_i = 1'b0;
  logic        enable_i = 1'b0, clear_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic signed [15:0] cos_o, sin_o;

  int total = 0, bad = 0;
  bit done = 0;
  bit live = 0;
  string cur = "R1";

  nco_quad dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int rnd(real v);
    if (v >= 0.0) return $rtoi($floor(v + 0.5));
    return -$rtoi($floor(-v + 0.5));
  endfunction

  function automatic real ang(logic [31:0] ph);
    return 2.0 * PI * (real'(ph[31:22]) + 0.5) / 1024.0;
  endfunction

  // behavioural reference
  logic [31:0] m_acc, m_frq, m_hf, m_p1;
  logic [15:0] m_off, m_ho;
  int m_c2, m_s2, m_c3, m_s3;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_acc = 0; m_frq = 0; m_hf = 0; m_p1 = 0; m_off = 0; m_ho = 0;
      m_c2 = 0; m_s2 = 0; m_c3 = 0; m_s3 = 0;
    end else begin
      m_c3 = m_c2; m_s3 = m_s2;
      m_c2 = rnd(32767.0 * $cos(ang(m_p1)));
      m_s2 = rnd(32767.0 * $sin(ang(m_p1)));
      m_p1 = m_acc + {m_off, 16'h0};
      if (clear_i) m_acc = 0;
      else if (enable_i) m_acc = m_acc + m_frq;
      if (load_i) begin m_frq = m_hf; m_off = m_ho; end
      if (wr_en_i) begin
        if (wr_sel_i) m_ho = wr_data_i[15:0];
        else m_hf = wr_data_i;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison; covers R8 values and R9 latency
  always @(negedge clk_i) begin
    if (live && rst_ni) begin
      chk({cur, "/R8/R9 cos"}, int'(cos_o), m_c3);
      chk({cur, "/R8/R9 sin"}, int'(sin_o), m_s3);
      if (sin_o == -16'sd32768 || cos_o == -16'sd32768) chk("R10", 1, 0);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(bit sel, logic [31:0] d, bit ld);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d; load_i = ld;
    @(negedge clk_i);
    wr_en_i = 1'b0; load_i = 1'b0;
  endtask

  task automatic load();
    @(negedge clk_i); load_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    run(3);
    chk("R1 cos", int'(cos_o), 0);
    chk("R1 sin", int'(sin_o), 0);
    rst_ni = 1'b1;
    live = 1;
    run(5);
    cur = "R2";
    wr(1'b0, 32'h0100_0000, 1'b0);
    wr(1'b1, 32'hABCD_4000, 1'b0);
    run(6);
    chk("R2 cos static", int'(cos_o), 32767);
    cur = "R3";
    load();
    enable_i = 1'b1;
    run(30);
    cur = "R3";
    wr(1'b0, 32'hFFC0_0000, 1'b0);
    wr(1'b0, 32'h0080_0000, 1'b1); // load commits 0xFFC00000
    run(25);
    cur = "R4";
    wr(1'b0, 32'h7FFF_FFFF, 1'b1);
    run(20);
    cur = "R7";
    wr(1'b1, 32'h0000_FFFF, 1'b0);
    wr(1'b0, 32'h0040_0000, 1'b0);
    load();
    run(12);
    wr(1'b1, 32'h0000_8000, 1'b1);
    run(12);
    cur = "R5";
    enable_i = 1'b0;
    run(12);
    enable_i = 1'b1;
    cur = "R6";
    @(negedge clk_i); clear_i = 1'b1;
    run(4);
    clear_i = 1'b0; enable_i = 1'b0;
    run(5);
    enable_i = 1'b1;
    cur = "R8";
    wr(1'b1, 32'h0, 1'b1);
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
    run(1030);
    cur = "R9";
    wr(1'b1, 32'h0000_C000, 1'b1);
    run(8);
    finish_run();
  end
endmodule